// File: doc/BRIEF.md
# Multi-Phase SPI Command Sequencer

This block runs a chain of SPI transfer phases from a bank of command words. Each phase has its own 16-bit command. The command sets the clock mode, the bit order, the frame length code, the lane width and direction, whether chip-select stays asserted after the phase, and which of three programmable delays apply. Each phase also has a 32-bit unit count that says how many data units it moves before the sequencer moves on. A sequence-length input picks how many commands run. A status output shows which command is active.

The sequencer does not shift bits itself. It drives a chip-select bus and a transfer-enable strobe. It also presents the active command word and its decoded lane mode to an external shift engine. That engine returns one acknowledge per data unit, and a bit-clock tick paces all delays. Commands and unit counts are written through a small write port into live registers. At each start these are copied into a shadow bank, so a run in progress is never disturbed.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_ptr` are 0. Every `cs_out` line sits at its inactive level, which is the inverse of its `cs_pol` bit.
- R2: A `start` pulse while idle runs commands 0 through `seq_last` in order. `cmd_ptr` shows the active index and returns to 0 when the run ends. A `start` pulse while busy is ignored.
- R3: A phase stays in transfer (`xfer_en` high) until it has received as many `unit_done` acknowledges as its unit count (written with `wr_sel`=1). A count of 0 is treated as 1.
- R4: Before each phase's transfer, chip-select is asserted for a lead delay. The delay is `dly_lead`+1 bit ticks when command bit 15 is set, and 1 tick otherwise.
- R5: When command bit 7 is clear, a trail delay follows the transfer with chip-select still asserted. The trail delay is `dly_trail`+1 ticks if bit 14 is set, else 1 tick. A gap delay then follows with chip-select negated. The gap delay is `dly_gap`+1 ticks if bit 13 is set, else 1 tick.
- R6: When command bit 7 is set, there is no trail or gap delay and chip-select stays asserted into the next phase. If that command is the final one, chip-select is still asserted after the run ends.
- R7: `done` is a single-cycle pulse. It appears in the first idle cycle after the final phase, and `busy` is low in that same cycle.
- R8: Only the line chosen by `cs_sel` is ever asserted. A set `cs_pol` bit makes its line active-high and a clear bit makes it active-low.
- R9: `ph_cmd` carries the active command word. Command bits 6:5 set `ph_lanes`: 00 gives 3'b001, 01 gives 3'b010, 10 gives 3'b100, and 11 gives 3'b001. `ph_read` is command bit 4 only when the lane width is above one.
- R10: Writes to commands or unit counts made during a run do not change that run. They take effect at the next start.
- R11: All delays count `bit_tick` pulses, not clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the live bank |
| wr_sel | input | 1 | 0 selects a command word, 1 selects a unit count |
| wr_idx | input | 3 | Entry index |
| wr_data | input | 32 | Write data (a command uses bits 15:0) |
| seq_last | input | 3 | Index of the final command, sampled at start |
| dly_lead | input | 3 | Lead delay code, sampled at start |
| dly_trail | input | 3 | Trail delay code, sampled at start |
| dly_gap | input | 3 | Gap delay code, sampled at start |
| cs_sel | input | 2 | Chip-select line to drive |
| cs_pol | input | 4 | Per-line active level |
| start | input | 1 | Start pulse |
| bit_tick | input | 1 | One pulse per bit-clock period |
| unit_done | input | 1 | Shift engine finished one data unit |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cmd_ptr | output | 3 | Index of the active command |
| xfer_en | output | 1 | Shift engine enable |
| ph_cmd | output | 16 | Active command word |
| ph_lanes | output | 3 | One-hot lane width (1, 2 or 4) |
| ph_read | output | 1 | Multi-lane phase reads |
| cs_out | output | 4 | Chip-select lines |

## Verification
Several rules hold on every cycle, and properties check them continuously:
- `done` never lasts two cycles and never appears while busy.
- The pointer stays within the sampled sequence length and only steps by one.
- The selected chip-select is active whenever the transfer enable is high.
- The lane output is one-hot.
- The shadow bank changes only at a start.

The exact length of each run can only be shown by the bench's scenarios. That length is the sum of the lead, transfer, trail and gap cycles for a given mix of enables, keep bits and unit counts. The scenarios also cover the treatment of a zero unit count, the hold of chip-select after a final kept phase, the isolation of mid-run writes and tick-paced delays.

// File: rtl/spi_seq_pkg.sv
// Package: shared state type, command bit positions and lane decode for the
// SPI command sequencer. Assumes 16-bit command words.
package spi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_XFER  = 3'd2,
        ST_TRAIL = 3'd3,
        ST_GAP   = 3'd4
    } seq_state_t;

    localparam int CB_READ     = 4;
    localparam int CB_LANE_LO  = 5;
    localparam int CB_KEEP     = 7;
    localparam int CB_GAP_EN   = 13;
    localparam int CB_TRAIL_EN = 14;
    localparam int CB_LEAD_EN  = 15;

    // Map the two lane bits to a one-hot width; the reserved code acts as single.
    function automatic logic [2:0] lane_decode(input logic [1:0] code);
        case (code)
            2'b01:   return 3'b010;
            2'b10:   return 3'b100;
            default: return 3'b001;
        endcase
    endfunction

endpackage

// File: rtl/seq_bank.sv
// Command and unit-count bank: live registers written at any time, plus a
// shadow copy taken on load that the running sequence reads.
// Assumes load is a single-cycle pulse issued at start.
module seq_bank #(
    parameter int NCMD = 8,
    parameter int CMDW = 16,
    parameter int LENW = 32,
    localparam int IDXW = $clog2(NCMD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [LENW-1:0] wr_data,
    input  logic            load,
    input  logic [IDXW-1:0] rd_idx,
    output logic [CMDW-1:0] cmd_o,
    output logic [LENW-1:0] len_o
);

    logic [CMDW-1:0] live_cmd [NCMD];
    logic [LENW-1:0] live_len [NCMD];
    logic [CMDW-1:0] sh_cmd   [NCMD];
    logic [LENW-1:0] sh_len   [NCMD];

    for (genvar i = 0; i < NCMD; i++) begin : g_ent
        // Live entry update from the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_cmd[i] <= '0;
                live_len[i] <= '0;
            end else if (wr_en && wr_idx == IDXW'(i)) begin
                if (wr_sel) live_len[i] <= wr_data;
                else        live_cmd[i] <= wr_data[CMDW-1:0];
            end
        end

        // Shadow entry capture at start.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_cmd[i] <= '0;
                sh_len[i] <= '0;
            end else if (load) begin
                sh_cmd[i] <= live_cmd[i];
                sh_len[i] <= live_len[i];
            end
        end

        assert_shadow_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> ($stable(sh_cmd[i]) && $stable(sh_len[i])));
    end

    // Read the active entry.
    assign cmd_o = sh_cmd[rd_idx];
    assign len_o = sh_len[rd_idx];

endmodule

// File: rtl/seq_delay.sv
// Tick-paced delay counter: while run is high, counts bit ticks and flags
// expire on the tick that completes (dly+1) ticks when dly_en is set, else 1.
// Assumes the caller switches delay selection only on expire.
module seq_delay #(
    parameter int DW = 3,
    localparam int CW = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          tick,
    input  logic          dly_en,
    input  logic [DW-1:0] dly,
    output logic          expire
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] target;

    // Number of ticks the current delay lasts.
    assign target = dly_en ? ({1'b0, dly} + CW'(1)) : CW'(1);
    assign expire = run && tick && (cnt == target - CW'(1));

    // Tick counter, cleared at start and at each expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || expire) cnt <= '0;
        else if (run && tick)        cnt <= cnt + CW'(1);
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < target));

endmodule

// File: rtl/seq_csdrv.sv
// Chip-select driver: drives the selected line to its active level when
// on is high; every other line holds its inactive level.
module seq_csdrv #(
    parameter int NCS = 4,
    localparam int CSW = $clog2(NCS)
) (
    input  logic           on,
    input  logic [CSW-1:0] sel,
    input  logic [NCS-1:0] pol,
    output logic [NCS-1:0] cs
);

    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign cs[i] = (on && sel == CSW'(i)) ? pol[i] : ~pol[i];
    end

endmodule

// File: rtl/spi_cmd_sequencer.sv
// SPI command sequencer top: steps through the shadowed command bank,
// applying lead, transfer, trail and gap stages per phase, and drives
// chip-select and the shift-engine enable. Assumes the shift engine raises
// unit_done for one cycle per finished data unit while xfer_en is high.
module spi_cmd_sequencer
    import spi_seq_pkg::*;
#(
    parameter int NCMD = 8,
    parameter int CMDW = 16,
    parameter int LENW = 32,
    parameter int DW   = 3,
    parameter int NCS  = 4,
    localparam int IDXW = $clog2(NCMD),
    localparam int CSW  = $clog2(NCS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [LENW-1:0] wr_data,
    input  logic [IDXW-1:0] seq_last,
    input  logic [DW-1:0]   dly_lead,
    input  logic [DW-1:0]   dly_trail,
    input  logic [DW-1:0]   dly_gap,
    input  logic [CSW-1:0]  cs_sel,
    input  logic [NCS-1:0]  cs_pol,
    input  logic            start,
    input  logic            bit_tick,
    input  logic            unit_done,
    output logic            busy,
    output logic            done,
    output logic [IDXW-1:0] cmd_ptr,
    output logic            xfer_en,
    output logic [CMDW-1:0] ph_cmd,
    output logic [2:0]      ph_lanes,
    output logic            ph_read,
    output logic [NCS-1:0]  cs_out
);

    seq_state_t      state;
    logic [IDXW-1:0] ptr, last_q;
    logic [DW-1:0]   dl_q, dt_q, dg_q;
    logic [LENW-1:0] ucnt, len, len_last;
    logic [CMDW-1:0] cmd;
    logic            hold_q, done_q;
    logic            go, dly_run, dly_en, expire, unit_last, is_last, cs_on;
    logic [DW-1:0]   dly_sel;

    assign go = start && (state == ST_IDLE);

    seq_bank #(.NCMD(NCMD), .CMDW(CMDW), .LENW(LENW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_idx(wr_idx), .wr_data(wr_data), .load(go), .rd_idx(ptr),
        .cmd_o(cmd), .len_o(len)
    );

    // Pick the delay code and enable for the current stage.
    always_comb begin
        dly_run = 1'b1;
        case (state)
            ST_LEAD:  begin dly_en = cmd[CB_LEAD_EN];  dly_sel = dl_q; end
            ST_TRAIL: begin dly_en = cmd[CB_TRAIL_EN]; dly_sel = dt_q; end
            ST_GAP:   begin dly_en = cmd[CB_GAP_EN];   dly_sel = dg_q; end
            default:  begin dly_en = 1'b0; dly_sel = '0; dly_run = 1'b0; end
        endcase
    end

    seq_delay #(.DW(DW)) u_delay (
        .clk(clk), .rst_n(rst_n), .clr(go), .run(dly_run), .tick(bit_tick),
        .dly_en(dly_en), .dly(dly_sel), .expire(expire)
    );

    // A zero unit count runs one unit.
    assign len_last  = (len == '0) ? '0 : len - LENW'(1);
    assign unit_last = (state == ST_XFER) && unit_done && (ucnt == len_last);
    assign is_last   = (ptr == last_q);

    // Phase stepping, pointer, unit count, chip-select hold and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            last_q <= '0;
            dl_q   <= '0;
            dt_q   <= '0;
            dg_q   <= '0;
            ucnt   <= '0;
            hold_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (go) begin
                    state  <= ST_LEAD;
                    ptr    <= '0;
                    last_q <= seq_last;
                    dl_q   <= dly_lead;
                    dt_q   <= dly_trail;
                    dg_q   <= dly_gap;
                    hold_q <= 1'b0;
                end
                ST_LEAD: if (expire) begin
                    state <= ST_XFER;
                    ucnt  <= '0;
                end
                ST_XFER: begin
                    if (unit_done) ucnt <= ucnt + LENW'(1);
                    if (unit_last) begin
                        if (!cmd[CB_KEEP]) begin
                            state <= ST_TRAIL;
                        end else if (is_last) begin
                            state  <= ST_IDLE;
                            ptr    <= '0;
                            hold_q <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_LEAD;
                            ptr   <= ptr + IDXW'(1);
                        end
                    end
                end
                ST_TRAIL: if (expire) state <= ST_GAP;
                ST_GAP: if (expire) begin
                    if (is_last) begin
                        state  <= ST_IDLE;
                        ptr    <= '0;
                        done_q <= 1'b1;
                    end else begin
                        state <= ST_LEAD;
                        ptr   <= ptr + IDXW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cs_on = hold_q || (state == ST_LEAD) || (state == ST_XFER) || (state == ST_TRAIL);

    seq_csdrv #(.NCS(NCS)) u_cs (
        .on(cs_on), .sel(cs_sel), .pol(cs_pol), .cs(cs_out)
    );

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign cmd_ptr  = ptr;
    assign xfer_en  = (state == ST_XFER);
    assign ph_cmd   = cmd;
    assign ph_lanes = lane_decode(cmd[CB_LANE_LO+1:CB_LANE_LO]);
    assign ph_read  = cmd[CB_READ] && (ph_lanes != 3'b001);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cmd_ptr <= last_q));
    assert_ptr_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cmd_ptr == '0));
    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (cmd_ptr != $past(cmd_ptr))) |-> (cmd_ptr == $past(cmd_ptr) + IDXW'(1)));
    assert_xfer_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |-> (cs_out[cs_sel] == cs_pol[cs_sel]));
    assert_lanes_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ph_lanes) == 1);

endmodule

// File: tb/tb_spi_cmd_sequencer.sv
module tb_spi_cmd_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  seq_last = '0, dly_lead = '0, dly_trail = '0, dly_gap = '0;
    logic [1:0]  cs_sel = '0;
    logic [3:0]  cs_pol = '0;
    logic        start = 1'b0;
    logic        half = 1'b0, tgl = 1'b0;
    logic        bit_tick, unit_done;
    logic        busy, done, xfer_en, ph_read;
    logic [2:0]  cmd_ptr, ph_lanes;
    logic [15:0] ph_cmd;
    logic [3:0]  cs_out;

    int tests = 0, fails = 0;
    int nb, nx, maxp, post_done;
    logic [3:0]  cs_done, cs_x;
    logic [2:0]  lanes_x;
    logic        read_x;
    logic [15:0] cmd_x;

    always #4 clk = ~clk;
    always @(negedge clk) tgl <= ~tgl;
    assign bit_tick  = half ? tgl : 1'b1;
    assign unit_done = xfer_en & bit_tick;

    spi_cmd_sequencer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .seq_last(seq_last), .dly_lead(dly_lead),
        .dly_trail(dly_trail), .dly_gap(dly_gap), .cs_sel(cs_sel), .cs_pol(cs_pol),
        .start(start), .bit_tick(bit_tick), .unit_done(unit_done), .busy(busy),
        .done(done), .cmd_ptr(cmd_ptr), .xfer_en(xfer_en), .ph_cmd(ph_cmd),
        .ph_lanes(ph_lanes), .ph_read(ph_read), .cs_out(cs_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Start a run and observe it until done; midact injects a write and a start at cycle 1.
    task automatic run(input logic [2:0] last, input bit midact);
        int t;
        bit seen;
        @(negedge clk);
        seq_last = last; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nb = 0; nx = 0; maxp = 0; seen = 0; t = 0;
        while (!seen && t < 2000) begin
            if (busy) nb++;
            if (xfer_en) begin
                if (nx == 0) begin cs_x = cs_out; lanes_x = ph_lanes; read_x = ph_read; cmd_x = ph_cmd; end
                nx++;
            end
            if (int'(cmd_ptr) > maxp) maxp = int'(cmd_ptr);
            if (done) begin seen = 1; cs_done = cs_out; end
            if (midact && t == 1) begin
                start = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_idx = 3'd0; wr_data = 32'd6;
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
            t++;
            @(negedge clk);
        end
        post_done = int'(done);
        chk("R7 run reached done", int'(seen), 1);
    endtask

    // {last[3], cmd[16], keepmask[8], lenbase[8], lead[3], trail[3], gap[3]}
    localparam logic [43:0] VEC [5] = '{
        {3'd0, 16'h0000, 8'h00, 8'd1, 3'd0, 3'd0, 3'd0},
        {3'd2, 16'hE000, 8'h00, 8'd2, 3'd2, 3'd1, 3'd3},
        {3'd7, 16'h0080, 8'h00, 8'd1, 3'd0, 3'd0, 3'd0},
        {3'd3, 16'h8000, 8'h05, 8'd0, 3'd4, 3'd0, 3'd0},
        {3'd1, 16'h4000, 8'h00, 8'd5, 3'd0, 3'd7, 3'd0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 cmd_ptr", int'(cmd_ptr), 0);
        chk("R1 cs idle", int'(cs_out), 15);
        rst_n = 1'b1;

        for (int v = 0; v < 5; v++) begin
            logic [2:0] last, dl, dt, dg;
            logic [15:0] base, c;
            logic [7:0] km, lb;
            int eb, ex, L, lastkeep;
            {last, base, km, lb, dl, dt, dg} = VEC[v];
            dly_lead = dl; dly_trail = dt; dly_gap = dg;
            eb = 0; ex = 0; lastkeep = 0;
            for (int p = 0; p < 8; p++) begin
                c = base ^ (km[p] ? 16'h0080 : 16'h0000);
                wr(1'b0, 3'(p), {16'h0, c});
                wr(1'b1, 3'(p), 32'(lb) + 32'(p));
                if (p <= int'(last)) begin
                    L = int'(lb) + p;
                    if (L == 0) L = 1;
                    eb += (c[15] ? int'(dl) + 1 : 1) + L;
                    ex += L;
                    if (!c[7]) eb += (c[14] ? int'(dt) + 1 : 1) + (c[13] ? int'(dg) + 1 : 1);
                    lastkeep = int'(c[7]);
                end
            end
            run(last, 1'b0);
            chk("R4 R5 R6 busy cycles", nb, eb);
            chk("R3 transfer units", nx, ex);
            chk("R2 highest pointer", maxp, int'(last));
            chk("R2 pointer back to 0", int'(cmd_ptr), 0);
            chk("R7 done single", post_done, 0);
            chk("R6 cs after done", int'(cs_done[0] == cs_pol[0]), lastkeep);
        end

        // R8: polarity and select
        cs_pol = 4'b0101; cs_sel = 2'd2;
        dly_lead = 0; dly_trail = 0; dly_gap = 0;
        @(negedge clk);
        chk("R8 idle levels", int'(cs_out), 4'b1010);
        wr(1'b0, 3'd0, 32'h0050);
        wr(1'b1, 3'd0, 32'd3);
        run(3'd0, 1'b0);
        chk("R8 active levels", int'(cs_x), 4'b1110);
        chk("R9 quad lanes", int'(lanes_x), 3'b100);
        chk("R9 quad read", int'(read_x), 1);
        chk("R9 command word", int'(cmd_x), 16'h0050);
        wr(1'b0, 3'd0, 32'h0010);
        run(3'd0, 1'b0);
        chk("R9 single lane", int'(lanes_x), 3'b001);
        chk("R9 single ignores read", int'(read_x), 0);
        wr(1'b0, 3'd0, 32'h0060);
        run(3'd0, 1'b0);
        chk("R9 reserved code", int'(lanes_x), 3'b001);
        wr(1'b0, 3'd0, 32'h0030);
        run(3'd0, 1'b0);
        chk("R9 dual lanes", int'(lanes_x), 3'b010);
        chk("R9 dual read", int'(read_x), 1);

        // R10 and R2: mid-run write and start are not seen by the current run
        cs_pol = 4'b0000; cs_sel = 2'd0;
        wr(1'b0, 3'd0, 32'h0000);
        wr(1'b1, 3'd0, 32'd3);
        run(3'd0, 1'b1);
        chk("R10 current run unchanged", nx, 3);
        chk("R2 start while busy ignored", nb, 6);
        run(3'd0, 1'b0);
        chk("R10 next run uses write", nx, 6);

        // R3: zero count acts as one
        wr(1'b1, 3'd0, 32'd0);
        run(3'd0, 1'b0);
        chk("R3 zero count", nx, 1);

        // R11: half-rate ticks double every stage
        half = 1'b1;
        dly_lead = 3'd1; dly_trail = 3'd1; dly_gap = 3'd1;
        wr(1'b0, 3'd0, 32'hE000);
        wr(1'b1, 3'd0, 32'd2);
        run(3'd0, 1'b0);
        chk("R11 tick paced length", int'(nb >= 15 && nb <= 17), 1);
        half = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule